// File: doc/BRIEF.md
# Stratum End Controller

This per-core block decides when its core stops issuing instructions for the current stratum, and it adapts how long the next stratum may run. While the core runs, an elapsed counter advances. It counts clock cycles in the conventional mode and retired instructions in the two deterministic modes. A stratum ends when that count reaches the current limit, when a serializing or atomic instruction completes, or, outside the unbounded mode, when a core resource reports full. The core then raises a barrier-arrive flag and holds there until the barrier network releases it.

While the core waits at the barrier, it drives a one-bit vote into a chip-wide OR. The vote is high when its stratum ended on an atomic, or on resource exhaustion in the conventional or bounded mode. On release, every core samples the same global OR and steps its own copy of a two-bit saturating counter. Because all copies see the same input, they stay identical. When the counter reaches an extreme, the limit doubles or halves within 64 to 4096, and the counter returns to its centre value. Interrupt requests are latched and handed to the core only as a new stratum starts.

The controller has two named states. RUN lets the core issue. WAIT means the core is parked at the barrier. There are two transitions. RUN goes to WAIT on the first end condition. WAIT goes to RUN on barrier release.

Top module: `stratum_ctrl`

## Requirements
- R1: After reset the block is in RUN: issue_en_o=1, bar_arrive_o=0, or_vote_o=0, irq_o=0, and limit_o=64.
- R2: With mode_i=2'b00 (conventional), RUN lasts exactly limit_o clock cycles after a release, and then the block enters WAIT.
- R3: With mode_i=2'b01 (bounded), only cycles with retire_i=1 advance the count. The block enters WAIT on the clock edge that sees the limit_o-th retire.
- R4: In RUN, a cycle with serial_i=1 or atom_i=1 moves the block to WAIT on the next edge, in every mode.
- R5: res_full_i=1 in RUN ends the stratum on the next edge when mode_i is 2'b00 or 2'b01. It has no effect when mode_i is 2'b10 or 2'b11 (both unbounded).
- R6: In WAIT, issue_en_o=0 and bar_arrive_o=1, and the retire, serializing and atomic inputs are ignored. The block stays in WAIT until bar_release_i=1. On that edge the elapsed count restarts from zero.
- R7: In WAIT, or_vote_o=1 exactly when the stratum ended with atom_i=1, or with res_full_i=1 in mode 2'b00 or 2'b01. In RUN, or_vote_o=0.
- R8: On each release edge the two-bit counter steps down if or_in_i=1 and up otherwise. It starts at 1. A step that reaches 3 doubles limit_o. A step that reaches 0 halves limit_o. After either change the counter returns to 1.
- R9: limit_o never goes above 4096 or below 64. A doubling at 4096 or a halving at 64 leaves limit_o unchanged but still returns the counter to 1.
- R10: irq_o is high for only one cycle: the first cycle after a release. It is high then only if irq_req_i was seen since the previous presentation, including on the release cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Determinism mode: 00 conventional, 01 bounded, 10/11 unbounded |
| retire_i | input | 1 | One instruction retired this cycle |
| serial_i | input | 1 | Serializing instruction completed this cycle |
| atom_i | input | 1 | Atomic operation completed this cycle |
| res_full_i | input | 1 | A core resource (e.g. write buffer) is full |
| irq_req_i | input | 1 | Interrupt request from outside |
| bar_release_i | input | 1 | Barrier network releases waiting cores |
| or_in_i | input | 1 | Chip-wide OR of all cores' votes, valid at release |
| issue_en_o | output | 1 | Core may issue instructions |
| bar_arrive_o | output | 1 | Core has reached the barrier |
| or_vote_o | output | 1 | This core's contribution to the chip-wide OR |
| irq_o | output | 1 | Deferred interrupt presented at a stratum start |
| limit_o | output | 13 | Current stratum limit (power of two) |

## Verification
The hardest condition to reach is a limit change at the clamps. This happens at the top value of 4096, where a natural stratum runs for thousands of cycles, and again at the floor of 64 under steady decrements. The stimulus avoids long waits. It runs in unbounded mode with no retires and closes each stratum with a single serializing pulse. It then chooses the global OR value at each release, so it walks the counter through every step, both clamps and the recentring rule in a few hundred cycles. Separate directed runs hold res_full_i high in both unbounded encodings. They show that no stratum end occurs, and that a later serializing end still votes zero.

// File: rtl/strat_pkg.sv
`timescale 1ns/1ps
package strat_pkg;
    typedef enum logic [1:0] {
        MODE_CONV  = 2'b00,
        MODE_BOUND = 2'b01,
        MODE_UNB   = 2'b10,
        MODE_UNB2  = 2'b11
    } mode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    localparam logic [1:0] PRED_MID = 2'd1;
    localparam logic [1:0] PRED_TOP = 2'd3;
    localparam logic [1:0] PRED_BOT = 2'd0;

    // resource exhaustion may end a stratum only outside unbounded modes
    function automatic logic res_may_end(input mode_e m);
        return (m == MODE_CONV) || (m == MODE_BOUND);
    endfunction
endpackage

// File: rtl/strat_elapsed.sv
`timescale 1ns/1ps
module strat_elapsed #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/strat_predictor.sv
`timescale 1ns/1ps
module strat_predictor
    import strat_pkg::*;
#(
    parameter int MIN_LOG  = 6,
    parameter int MAX_LOG  = 12,
    parameter int INIT_LOG = 6,
    localparam int LIM_W   = MAX_LOG + 1,
    localparam int EXP_W   = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             dec,
    output logic [LIM_W-1:0] limit
);
    logic [1:0]       ctr_q;
    logic [1:0]       ctr_step;
    logic [EXP_W-1:0] exp_q;

    always_comb begin
        ctr_step = dec ? (ctr_q - 2'd1) : (ctr_q + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= PRED_MID;
            exp_q <= EXP_W'(INIT_LOG);
        end else if (upd) begin
            if (ctr_step == PRED_TOP) begin
                ctr_q <= PRED_MID;
                if (exp_q < EXP_W'(MAX_LOG)) exp_q <= exp_q + EXP_W'(1);
            end else if (ctr_step == PRED_BOT) begin
                ctr_q <= PRED_MID;
                if (exp_q > EXP_W'(MIN_LOG)) exp_q <= exp_q - EXP_W'(1);
            end else begin
                ctr_q <= ctr_step;
            end
        end
    end

    assign limit = LIM_W'(1) << exp_q;
endmodule

// File: rtl/strat_irq_hold.sv
`timescale 1ns/1ps
module strat_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic present,
    output logic irq
);
    logic pend_q;
    logic pend_n;

    assign pend_n = pend_q | req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq    <= 1'b0;
        end else if (present) begin
            pend_q <= 1'b0;
            irq    <= pend_n;
        end else begin
            pend_q <= pend_n;
            irq    <= 1'b0;
        end
    end
endmodule

// File: rtl/stratum_ctrl.sv
`timescale 1ns/1ps
module stratum_ctrl
    import strat_pkg::*;
#(
    parameter int MIN_LOG  = 6,
    parameter int MAX_LOG  = 12,
    parameter int INIT_LOG = 6,
    localparam int LIM_W   = MAX_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             retire_i,
    input  logic             serial_i,
    input  logic             atom_i,
    input  logic             res_full_i,
    input  logic             irq_req_i,
    input  logic             bar_release_i,
    input  logic             or_in_i,
    output logic             issue_en_o,
    output logic             bar_arrive_o,
    output logic             or_vote_o,
    output logic             irq_o,
    output logic [LIM_W-1:0] limit_o
);
    localparam int CNT_W = LIM_W;

    state_e           state_q, state_d;
    mode_e            mode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_plus;
    logic             count_inc;
    logic             hit_limit;
    logic             res_end;
    logic             end_now;
    logic             release_now;
    logic             atom_q, resx_q;

    assign mode = mode_e'(mode_i);

    always_comb begin
        count_inc   = (state_q == ST_RUN) && ((mode == MODE_CONV) ? 1'b1 : retire_i);
        cnt_plus    = {1'b0, cnt} + {{CNT_W{1'b0}}, count_inc};
        hit_limit   = cnt_plus >= {1'b0, limit_o};
        res_end     = res_full_i && res_may_end(mode);
        end_now     = hit_limit || serial_i || atom_i || res_end;
        release_now = (state_q == ST_WAIT) && bar_release_i;
    end

    strat_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (release_now),
        .inc   (count_inc),
        .cnt   (cnt)
    );

    strat_predictor #(
        .MIN_LOG  (MIN_LOG),
        .MAX_LOG  (MAX_LOG),
        .INIT_LOG (INIT_LOG)
    ) u_pred (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (release_now),
        .dec   (or_in_i),
        .limit (limit_o)
    );

    strat_irq_hold u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req_i),
        .present (release_now),
        .irq     (irq_o)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (end_now)       state_d = ST_WAIT;
            ST_WAIT: if (bar_release_i) state_d = ST_RUN;
        endcase
    end

    // state register and end-reason capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            atom_q  <= 1'b0;
            resx_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && end_now) begin
                atom_q <= atom_i;
                resx_q <= res_end;
            end
        end
    end

    // Moore outputs
    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                issue_en_o   = 1'b1;
                bar_arrive_o = 1'b0;
                or_vote_o    = 1'b0;
            end
            ST_WAIT: begin
                issue_en_o   = 1'b0;
                bar_arrive_o = 1'b1;
                or_vote_o    = atom_q | resx_q;
            end
        endcase
    end
endmodule

// File: rtl/stratum_ctrl_chk.sv
`timescale 1ns/1ps
module stratum_ctrl_chk #(
    parameter int LIM_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             serial_i,
    input logic             atom_i,
    input logic             bar_release_i,
    input logic             issue_en_o,
    input logic             bar_arrive_o,
    input logic             or_vote_o,
    input logic             irq_o,
    input logic [LIM_W-1:0] limit_o
);
    assert_end_on_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en_o && (serial_i || atom_i)) |=> bar_arrive_o);

    assert_hold_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_arrive_o && !bar_release_i) |=> (bar_arrive_o && !issue_en_o));

    assert_vote_only_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        or_vote_o |-> bar_arrive_o);

    assert_limit_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bar_arrive_o && bar_release_i) |=> $stable(limit_o));

    assert_limit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_arrive_o && bar_release_i) |=>
            (limit_o == $past(limit_o) || limit_o == ($past(limit_o) << 1)
             || limit_o == ($past(limit_o) >> 1)));

    assert_limit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(limit_o) == 1) && (limit_o >= LIM_W'(64)) && (limit_o <= LIM_W'(4096)));

    assert_irq_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(bar_arrive_o && bar_release_i));
endmodule

bind stratum_ctrl stratum_ctrl_chk #(.LIM_W(LIM_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .serial_i      (serial_i),
    .atom_i        (atom_i),
    .bar_release_i (bar_release_i),
    .issue_en_o    (issue_en_o),
    .bar_arrive_o  (bar_arrive_o),
    .or_vote_o     (or_vote_o),
    .irq_o         (irq_o),
    .limit_o       (limit_o)
);

// File: tb/stratum_ctrl_bench.sv
`timescale 1ns/1ps
module stratum_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        retire_i = 1'b0, serial_i = 1'b0, atom_i = 1'b0, res_full_i = 1'b0;
    logic        irq_req_i = 1'b0, bar_release_i = 1'b0, or_in_i = 1'b0;
    logic        issue_en_o, bar_arrive_o, or_vote_o, irq_o;
    logic [12:0] limit_o;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    stratum_ctrl u_stratum_ctrl (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .retire_i (retire_i),
        .serial_i (serial_i), .atom_i (atom_i), .res_full_i (res_full_i),
        .irq_req_i (irq_req_i), .bar_release_i (bar_release_i), .or_in_i (or_in_i),
        .issue_en_o (issue_en_o), .bar_arrive_o (bar_arrive_o), .or_vote_o (or_vote_o),
        .irq_o (irq_o), .limit_o (limit_o)
    );

    // predictor walk: {or_in, expected limit after release}
    localparam logic [13:0] VEC [0:19] = '{
        {1'b0, 13'd64},   {1'b0, 13'd128},  {1'b1, 13'd64},   {1'b1, 13'd64},
        {1'b0, 13'd64},   {1'b0, 13'd128},  {1'b0, 13'd128},  {1'b0, 13'd256},
        {1'b0, 13'd256},  {1'b0, 13'd512},  {1'b0, 13'd512},  {1'b0, 13'd1024},
        {1'b0, 13'd1024}, {1'b0, 13'd2048}, {1'b0, 13'd2048}, {1'b0, 13'd4096},
        {1'b0, 13'd4096}, {1'b0, 13'd4096}, {1'b1, 13'd2048}, {1'b1, 13'd1024}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // one release; returns sampled in the first RUN cycle
    task automatic release_bar(input logic orv, input logic irq_same);
        @(negedge clk); bar_release_i = 1'b1; or_in_i = orv; irq_req_i = irq_same;
        @(negedge clk); bar_release_i = 1'b0; or_in_i = 1'b0; irq_req_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        chk("R1 issue_en", issue_en_o, 1);
        chk("R1 arrive", bar_arrive_o, 0);
        chk("R1 vote", or_vote_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 limit", limit_o, 64);
        rst_n = 1'b1;

        // R4 serializing end
        pulse(serial_i);
        chk("R4 serial end arrive", bar_arrive_o, 1);
        chk("R6 issue off waiting", issue_en_o, 0);
        chk("R7 vote after serial", or_vote_o, 0);

        // R6 inputs ignored while waiting
        @(negedge clk); atom_i = 1'b1; retire_i = 1'b1; serial_i = 1'b1;
        repeat (5) @(negedge clk);
        atom_i = 1'b0; retire_i = 1'b0; serial_i = 1'b0;
        @(negedge clk);
        chk("R6 still waiting", bar_arrive_o, 1);
        chk("R7 atomic while waiting ignored", or_vote_o, 0);

        // R2 conventional cycle count
        release_bar(1'b1, 1'b0);
        chk("R6 running after release", issue_en_o, 1);
        n = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (bar_arrive_o) break;
            n++;
        end
        chk("R2 conventional run length", n, 64);
        chk("R7 vote after count end", or_vote_o, 0);

        // R3 bounded: only retires count, restart from zero (R6)
        mode_i = 2'b01;
        release_bar(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R3 idle cycles not counted", bar_arrive_o, 0);
        bad = 0;
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk); retire_i = 1'b1;
            @(negedge clk); retire_i = 1'b0;
            if (bar_arrive_o != (k == 64)) bad++;
        end
        chk("R3 end on 64th retire", bad, 0);

        // R5 resource full in conventional and bounded
        mode_i = 2'b00;
        release_bar(1'b1, 1'b0);
        pulse(res_full_i);
        chk("R5 conventional res end", bar_arrive_o, 1);
        chk("R7 vote on res end", or_vote_o, 1);
        mode_i = 2'b01;
        release_bar(1'b1, 1'b0);
        pulse(res_full_i);
        chk("R5 bounded res end", bar_arrive_o, 1);
        chk("R7 vote on bounded res end", or_vote_o, 1);

        // R5 ignored in unbounded encodings
        mode_i = 2'b10;
        release_bar(1'b1, 1'b0);
        res_full_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 unbounded res ignored", bar_arrive_o, 0);
        serial_i = 1'b1;
        @(negedge clk); serial_i = 1'b0;
        @(negedge clk);
        res_full_i = 1'b0;
        chk("R4 serial end unbounded", bar_arrive_o, 1);
        chk("R7 no vote unbounded res", or_vote_o, 0);
        mode_i = 2'b11;
        release_bar(1'b1, 1'b0);
        res_full_i = 1'b1;
        repeat (10) @(negedge clk);
        res_full_i = 1'b0;
        chk("R5 mode 11 res ignored", bar_arrive_o, 0);
        pulse(serial_i);

        // R4 atomic ends stratum, R7 votes
        mode_i = 2'b00;
        release_bar(1'b1, 1'b0);
        pulse(atom_i);
        chk("R4 atomic end arrive", bar_arrive_o, 1);
        chk("R7 vote on atomic", or_vote_o, 1);

        // R10 interrupt deferral
        release_bar(1'b1, 1'b0);
        pulse(irq_req_i);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (irq_o) bad++;
        end
        chk("R10 irq held in run", bad, 0);
        pulse(serial_i);
        chk("R10 irq held waiting", irq_o, 0);
        release_bar(1'b1, 1'b0);
        chk("R10 irq at boundary", irq_o, 1);
        @(negedge clk);
        chk("R10 irq one cycle", irq_o, 0);
        pulse(serial_i);
        release_bar(1'b1, 1'b0);
        chk("R10 no irq without request", irq_o, 0);
        pulse(serial_i);
        release_bar(1'b1, 1'b1);
        chk("R10 irq on release cycle", irq_o, 1);

        // R8/R9 predictor walk in unbounded mode
        mode_i = 2'b10;
        for (int i = 0; i < 20; i++) begin
            pulse(serial_i);
            release_bar(VEC[i][13], 1'b0);
            chk((i == 3 || i == 17) ? "R9 limit clamp" : "R8 limit step",
                limit_o, VEC[i][12:0]);
        end

        finish_run();
    end
endmodule